// File: doc/BRIEF.md
# Comparator-Driven Set/Reset Latch Controller

This block holds one set/reset latch that two comparator results and software can drive. An 8-bit control register sits on a simple write/read bus. Its fields route two output signals, gate each comparator's path into the latch, and give software two write-one pulse bits that force the latch set or reset. Hardware clears the pulse bits at once.

Both comparator inputs are asynchronous. Each passes through a two-flop synchronizer before anything uses it. The synchronized levels are always visible on a status output, whatever the latch and the output routing are doing. Each output signal carries either the latch state or its own comparator's synchronized result. Analog comparators, pin direction and output-enable gating live outside this block.

Top module: `cmp_latch_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the latch is 0, and each output carries its own synchronized comparator result.
- R2: Control bit 6 selects the source of `pin_out[0]`: 1 gives the latch state, 0 gives synchronized comparator 0. Control bit 7 does the same for `pin_out[1]` with comparator 1.
- R3: When control bit 5 is 1, a synchronized high on comparator 0 sets the latch. When bit 5 is 0, comparator 0 has no effect on the latch.
- R4: When control bit 4 is 1, a synchronized high on comparator 1 resets the latch. When bit 4 is 0, comparator 1 has no effect on the latch.
- R5: A bus write with bit 3 = 1 sets the latch on that write's clock edge. Bit 3 always reads back 0.
- R6: A bus write with bit 2 = 1 resets the latch on that write's clock edge. Bit 2 always reads back 0.
- R7: Write data bits 1 and 0 are ignored and always read back 0.
- R8: When a set request (gated comparator 0 or bit-3 pulse) and a reset request (gated comparator 1 or bit-2 pulse) are active together, the latch ends at 0.
- R9: With no set or reset request the latch holds its value.
- R10: A change on a comparator input appears on `cmp_status` after two clock edges. If that comparator is enabled, the latch reacts on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| cmp_in | input | 2 | Asynchronous comparator results, [0] feeds set, [1] feeds reset |
| cmp_status | output | 2 | Synchronized comparator results |
| latch_q | output | 1 | Latch state |
| pin_out | output | 2 | Routed outputs |

## Verification
The assertions assume the comparator inputs settle to stable levels and that a bus write lasts exactly one cycle. The bench meets both assumptions: it drives every input on the falling clock edge and holds each comparator level for at least three cycles before it samples. Each latch case is set up first: the comparator enables are cleared, a pulse puts the latch in its starting state, and only then is the enable under test written. This means that every request seen by the latch comes from a single known cause.

// File: rtl/cl_pkg.sv
package cl_pkg;
  localparam int REG_W  = 8;
  localparam int B_SEL1 = 7;   // routes pin_out[1]
  localparam int B_SEL0 = 6;   // routes pin_out[0]
  localparam int B_SEN  = 5;
  localparam int B_REN  = 4;
  localparam int B_PSET = 3;
  localparam int B_PRST = 2;
  localparam logic [REG_W-1:0] STORE_MASK = 8'hF0;

  typedef struct packed {
    logic sel1;
    logic sel0;
    logic set_en;
    logic rst_en;
  } cl_cfg_t;

  // reset dominates set, otherwise hold
  function automatic logic sr_next(logic q, logic s, logic r);
    return r ? 1'b0 : (s ? 1'b1 : q);
  endfunction

  function automatic logic route(logic sel, logic q, logic cmp);
    return sel ? q : cmp;
  endfunction
endpackage

// File: rtl/cl_sync.sv
module cl_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [NS-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[NS-2:0], d[b]};
    end
    assign q[b] = chain[NS-1];
  end
endmodule

// File: rtl/cl_ctrl_reg.sv
module cl_ctrl_reg
  import cl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output cl_cfg_t          cfg,
  output logic [REG_W-1:0] rd_data,
  output logic             pulse_set,
  output logic             pulse_rst
);
  logic [REG_W-1:0] stored;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stored <= '0;
    else if (wr_en) stored <= wr_data & STORE_MASK;
  end

  assign cfg.sel1   = stored[B_SEL1];
  assign cfg.sel0   = stored[B_SEL0];
  assign cfg.set_en = stored[B_SEN];
  assign cfg.rst_en = stored[B_REN];
  assign rd_data    = stored;

  // self-clearing pulse bits: never stored, one-cycle request
  assign pulse_set = wr_en & wr_data[B_PSET];
  assign pulse_rst = wr_en & wr_data[B_PRST];
endmodule

// File: rtl/cl_sr_core.sv
module cl_sr_core
  import cl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic rst_req,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= sr_next(q, set_req, rst_req);
  end
endmodule

// File: rtl/cmp_latch_ctrl.sv
module cmp_latch_ctrl
  import cl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [1:0]       cmp_in,
  output logic [1:0]       cmp_status,
  output logic             latch_q,
  output logic [1:0]       pin_out
);
  localparam int N_CMP = 2;

  cl_cfg_t          cfg;
  logic             pulse_set, pulse_rst;
  logic [N_CMP-1:0] cmp_sync;
  logic             gated_set, gated_rst;
  logic             set_req, rst_req;
  logic [N_CMP-1:0] sel_vec;

  cl_sync #(.W(N_CMP), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_in), .q(cmp_sync)
  );

  cl_ctrl_reg i_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg(cfg), .rd_data(rd_data), .pulse_set(pulse_set), .pulse_rst(pulse_rst)
  );

  assign gated_set = cfg.set_en & cmp_sync[0];
  assign gated_rst = cfg.rst_en & cmp_sync[1];
  assign set_req   = gated_set | pulse_set;
  assign rst_req   = gated_rst | pulse_rst;

  cl_sr_core i_core (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .rst_req(rst_req), .q(latch_q)
  );

  assign sel_vec    = {cfg.sel1, cfg.sel0};
  assign cmp_status = cmp_sync;

  for (genvar i = 0; i < N_CMP; i++) begin : g_route
    assign pin_out[i] = route(sel_vec[i], latch_q, cmp_sync[i]);
  end
endmodule

// File: rtl/cl_checker.sv
module cl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rd_data,
  input logic [1:0] cmp_status,
  input logic       latch_q,
  input logic [1:0] pin_out,
  input logic       set_req,
  input logic       rst_req
);
  // R8: reset request dominates
  a_r8_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && rst_req) |=> !latch_q);
  // R3/R5: lone set request sets
  a_r5_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !rst_req) |=> latch_q);
  // R4/R6: reset request clears
  a_r6_reset_lands: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !latch_q);
  // R9: hold without request
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_req && !rst_req) |=> $stable(latch_q));
  // R5/R6/R7: low nibble always reads 0
  a_r7_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3:0] == 4'h0);
  // R2: latch routed when selected
  a_r2_route0: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6] |-> (pin_out[0] == latch_q));
  a_r2_route1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[7] |-> (pin_out[1] == cmp_status[1]));
endmodule

bind cmp_latch_ctrl cl_checker i_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .cmp_status(cmp_status),
  .latch_q(latch_q), .pin_out(pin_out), .set_req(set_req), .rst_req(rst_req)
);

// File: tb/test_cmp_latch_ctrl.sv
module test_cmp_latch_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [1:0] cmp_in = 2'b00;
  logic [1:0] cmp_status;
  logic       latch_q;
  logic [1:0] pin_out;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cmp_latch_ctrl i_cmp_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cmp_in(cmp_in), .cmp_status(cmp_status), .latch_q(latch_q), .pin_out(pin_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle write; returns after the write edge
  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic settle_cmp(input logic [1:0] c);
    @(negedge clk); cmp_in = c;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic init_q, exp_q;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 q", {7'b0, latch_q}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk); cmp_in = 2'b10;
    @(negedge clk);
    chk("R10 one edge", {6'b0, cmp_status}, 8'h00);
    @(negedge clk);
    chk("R10 two edges", {6'b0, cmp_status}, 8'h02);
    chk("R1 routing", {6'b0, pin_out}, 8'h02);
    settle_cmp(2'b00);

    // R7 / R5 / R6 readback
    wr(8'h03);
    chk("R7 low bits", rd_data, 8'h00);
    chk("R7 no effect", {7'b0, latch_q}, 8'h00);
    wr(8'h08);
    chk("R5 set pulse", {7'b0, latch_q}, 8'h01);
    chk("R5 readback", rd_data, 8'h00);
    wr(8'h00);
    chk("R9 hold", {7'b0, latch_q}, 8'h01);
    wr(8'h04);
    chk("R6 reset pulse", {7'b0, latch_q}, 8'h00);
    chk("R6 readback", rd_data, 8'h00);
    wr(8'h0C);
    chk("R8 both pulses", {7'b0, latch_q}, 8'h00);
    wr(8'h08);
    wr(8'hFF);
    chk("R8 all ones", {7'b0, latch_q}, 8'h00);
    chk("R7 all ones rd", rd_data, 8'hF0);
    wr(8'h00);

    // R3 R4 R8 R9: sweep enables, comparator levels and starting state
    for (int k = 0; k < 32; k++) begin
      logic se, re;
      logic [1:0] c;
      se = k[0]; re = k[1]; c = k[3:2]; init_q = k[4];
      wr(8'h00);
      settle_cmp(c);
      wr(init_q ? 8'h08 : 8'h04);
      wr({2'b11, se, re, 4'h0});
      @(negedge clk);
      exp_q = (re & c[1]) ? 1'b0 : ((se & c[0]) ? 1'b1 : init_q);
      chk("R3/R4/R8 sweep", {7'b0, latch_q}, {7'b0, exp_q});
      chk("R9 status", {6'b0, cmp_status}, {6'b0, c});
      chk("R2 latch routed", {6'b0, pin_out}, {6'b0, exp_q, exp_q});
    end

    // R2: every select pair, latch 1 against comparators 2'b01
    wr(8'h00);
    settle_cmp(2'b01);
    wr(8'h08);
    for (int s = 0; s < 4; s++) begin
      logic [1:0] sv;
      sv = s[1:0];
      wr({sv, 6'b0});
      chk("R2 select", {6'b0, pin_out},
          {6'b0, sv[1] ? 1'b1 : 1'b0, sv[0] ? 1'b1 : 1'b1});
      chk("R2 rd", rd_data, {sv, 6'b0});
    end
    settle_cmp(2'b10);
    wr(8'h00);
    chk("R2 cmp path", {6'b0, pin_out}, 8'h02);

    // R10: latch reacts on third edge after comparator change
    wr(8'h04);
    wr(8'h20);
    @(negedge clk); cmp_in = 2'b11;
    @(negedge clk); @(negedge clk);
    chk("R10 not yet", {7'b0, latch_q}, 8'h00);
    @(negedge clk);
    chk("R10 third edge", {7'b0, latch_q}, 8'h01);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule